// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Address Unit

This unit sits in the address path of a tiled surface that is stored in dual-channel memory. When the channels are interleaved, the memory flips channels on several address bits, not only on bit 6. A linear byte address therefore needs bit 6 corrected before it reaches memory. The unit does this by XORing a mode-dependent set of higher address bits into bit 6. The set is drawn from bits 9, 10, 11 and 17.

A decision stage reads a memory-configuration word and picks one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces. If the configuration reads as all ones, or is marked ambiguous, or holds a reserved arrangement, both modes fall back to "none" and a pin-pages flag is raised. That flag tells the page manager that pages must not be moved.

Addresses enter through a valid/ready handshake together with two sideband bits: a tiling select and the bit-17 value recorded for the page. They leave one register stage later. Each output carries a flag that is set when the page now sits on the other side of bit 17 than recorded. Such a page needs its 64-byte halves swapped within every 128 bytes. The unit only reports this case; it does not repair it.

Top module: `chan_swz_unit`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1, mode_x and mode_y are 0 (none) and pin_pages is 0.
- R2: In mode none (code 0), out_addr equals the accepted in_addr. In every mode, all bits other than bit 6 pass through unchanged.
- R3: Mode code 1 sets bit 6 to a6^a9. Mode code 2 sets bit 6 to a6^a9^a10.
- R4: Codes 3 and 4 are codes 1 and 2 with a11 also XORed into bit 6. Codes 5 and 6 are codes 1 and 2 with a17 also XORed into bit 6.
- R5: An address with in_ytile=0 uses mode_x; one with in_ytile=1 uses mode_y. out_ytile returns the select. mode_x is always 0, 2, 4 or 6, and mode_y is always 0, 1, 3 or 5.
- R6: The channel arrangement is cfg_word[1:0]. Arrangement 0 (single channel) and arrangement 1 (asymmetric dual) give mode_x=mode_y=0 and pin_pages=0.
- R7: Arrangement 2 (interleaved dual) decodes as follows. With cfg_word[2]=1 (channel XOR off), the modes are 2/1. Otherwise, with cfg_word[3]=1 (XOR on bit 17), they are 6/5. Otherwise they are 4/3.
- R8: The configuration is unusable when cfg_word is all ones, when cfg_word[4]=1 (ambiguous layout), or when the arrangement is 3. An unusable configuration gives mode_x=mode_y=0 and pin_pages=1.
- R9: out_b17_moved equals bit 17 of the accepted address XOR in_rec_b17.
- R10: There is one register stage. in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, the output holds its value.
- R11: mode_x, mode_y and pin_pages are registered. They reflect cfg_word as it stood at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | CFG_W | Memory configuration word |
| mode_x | output | 3 | Swizzle mode for X-tiled surfaces |
| mode_y | output | 3 | Swizzle mode for Y-tiled surfaces |
| pin_pages | output | 1 | Configuration unusable; pages must stay put |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Input can be accepted |
| in_addr | input | ADDR_W | Linear byte address |
| in_ytile | input | 1 | 1 = Y-tiled surface, 0 = X-tiled |
| in_rec_b17 | input | 1 | Recorded bit 17 of the page |
| out_valid | output | 1 | Output address valid |
| out_ready | input | 1 | Downstream accepts output |
| out_addr | output | ADDR_W | Swizzled address |
| out_ytile | output | 1 | Tiling select passed along |
| out_b17_moved | output | 1 | Page crossed bit 17; halves need swapping |

## Verification
The bench builds the unit with ADDR_W=40 and the default CFG_W=8. The wide address shows that bits above 32 pass through untouched. It also lets the configuration word reach the all-ones value as well as every arrangement code. Addresses are chosen so that bits 9, 10, 11 and 17 take on differing combinations, which makes each of the seven modes give a result distinct from its neighbours. A stall with out_ready low, followed by a back-to-back transfer, exercises the hold and ready rules.

// File: rtl/chan_swz_pkg.sv
package chan_swz_pkg;
  typedef enum logic [2:0] {
    SWZ_NONE      = 3'd0,
    SWZ_B9        = 3'd1,
    SWZ_B9_B10    = 3'd2,
    SWZ_B9_B11    = 3'd3,
    SWZ_B9_B10_11 = 3'd4,
    SWZ_B9_B17    = 3'd5,
    SWZ_B9_B10_17 = 3'd6
  } swz_mode_e;

  localparam int ARR_LSB      = 0;
  localparam int XOR_OFF_BIT  = 2;
  localparam int XOR_HI_BIT   = 3;
  localparam int AMBIG_BIT    = 4;
  localparam int CFG_MIN_W    = 5;
  localparam int ADDR_MIN_W   = 18;

  localparam logic [1:0] ARR_SINGLE = 2'd0;
  localparam logic [1:0] ARR_ASYM   = 2'd1;
  localparam logic [1:0] ARR_INTLV  = 2'd2;
endpackage

// File: rtl/chan_swz_mode_sel.sv
module chan_swz_mode_sel
  import chan_swz_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output swz_mode_e        mode_x_q,
  output swz_mode_e        mode_y_q,
  output logic             pin_q
);
  swz_mode_e  nx, ny;
  logic       npin;
  logic [1:0] arr;
  logic       unread;

  assign arr    = cfg_word[ARR_LSB +: 2];
  assign unread = &cfg_word;

  always_comb begin
    nx   = SWZ_NONE;
    ny   = SWZ_NONE;
    npin = 1'b0;
    if (unread || cfg_word[AMBIG_BIT]) begin
      npin = 1'b1;
    end else begin
      case (arr)
        ARR_SINGLE, ARR_ASYM: begin
          nx = SWZ_NONE;
          ny = SWZ_NONE;
        end
        ARR_INTLV: begin
          if (cfg_word[XOR_OFF_BIT]) begin
            nx = SWZ_B9_B10;
            ny = SWZ_B9;
          end else if (cfg_word[XOR_HI_BIT]) begin
            nx = SWZ_B9_B10_17;
            ny = SWZ_B9_B17;
          end else begin
            nx = SWZ_B9_B10_11;
            ny = SWZ_B9_B11;
          end
        end
        default: npin = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_x_q <= SWZ_NONE;
      mode_y_q <= SWZ_NONE;
      pin_q    <= 1'b0;
    end else begin
      mode_x_q <= nx;
      mode_y_q <= ny;
      pin_q    <= npin;
    end
  end

  initial begin
    if (CFG_W < CFG_MIN_W) $error("CFG_W too small");
  end

  // R8
  pin_none_chk: assert property (@(posedge clk) disable iff (rst)
    pin_q |-> (mode_x_q == SWZ_NONE && mode_y_q == SWZ_NONE));

  // R8
  unread_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&cfg_word)) |-> pin_q);

  // R5
  y_family_chk: assert property (@(posedge clk) disable iff (rst)
    mode_y_q inside {SWZ_NONE, SWZ_B9, SWZ_B9_B11, SWZ_B9_B17});

  // R5
  x_family_chk: assert property (@(posedge clk) disable iff (rst)
    mode_x_q inside {SWZ_NONE, SWZ_B9_B10, SWZ_B9_B10_11, SWZ_B9_B10_17});
endmodule

// File: rtl/chan_swz_xor.sv
module chan_swz_xor
  import chan_swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_mode_e         mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic use9, use10, use11, use17, flip;

  always_comb begin
    use9  = (mode_i != SWZ_NONE);
    use10 = mode_i inside {SWZ_B9_B10, SWZ_B9_B10_11, SWZ_B9_B10_17};
    use11 = mode_i inside {SWZ_B9_B11, SWZ_B9_B10_11};
    use17 = mode_i inside {SWZ_B9_B17, SWZ_B9_B10_17};
    flip  = (use9  & addr_i[9])  ^ (use10 & addr_i[10]) ^
            (use11 & addr_i[11]) ^ (use17 & addr_i[17]);
    addr_o    = addr_i;
    addr_o[6] = addr_i[6] ^ flip;
  end

  initial begin
    if (ADDR_W < ADDR_MIN_W) $error("ADDR_W too small");
  end
endmodule

// File: rtl/chan_swz_stage.sv
module chan_swz_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_ytile,
  input  logic              in_moved,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ytile,
  output logic              out_moved
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_ytile <= 1'b0;
      out_moved <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= in_addr;
        out_ytile <= in_ytile;
        out_moved <= in_moved;
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_ytile) && $stable(out_moved)));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/chan_swz_unit.sv
module chan_swz_unit
  import chan_swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [2:0]        mode_x,
  output logic [2:0]        mode_y,
  output logic              pin_pages,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_ytile,
  input  logic              in_rec_b17,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ytile,
  output logic              out_b17_moved
);
  swz_mode_e         mx_q, my_q, active_mode;
  logic [ADDR_W-1:0] swz_addr;
  logic              moved;

  chan_swz_mode_sel #(.CFG_W(CFG_W)) mode_sel_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .mode_x_q(mx_q), .mode_y_q(my_q), .pin_q(pin_pages)
  );

  assign mode_x      = mx_q;
  assign mode_y      = my_q;
  assign active_mode = in_ytile ? my_q : mx_q;
  assign moved       = in_addr[17] ^ in_rec_b17;

  chan_swz_xor #(.ADDR_W(ADDR_W)) xor_i (
    .addr_i(in_addr), .mode_i(active_mode), .addr_o(swz_addr)
  );

  chan_swz_stage #(.ADDR_W(ADDR_W)) stage_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(swz_addr), .in_ytile(in_ytile), .in_moved(moved),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_ytile(out_ytile), .out_moved(out_b17_moved)
  );

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (out_addr[ADDR_W-1:7] == $past(in_addr[ADDR_W-1:7]) &&
       out_addr[5:0] == $past(in_addr[5:0])));

  // R2
  none_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && active_mode == SWZ_NONE) |=>
      (out_addr == $past(in_addr)));

  // R9
  moved_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (out_b17_moved == ($past(in_addr[17]) ^ $past(in_rec_b17))));

  // R5
  ytile_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_ytile == $past(in_ytile)));
endmodule

// File: tb/chan_swz_unit_tb_top.sv
module chan_swz_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [CW-1:0] cfg_word;
  logic [2:0]    mode_x, mode_y;
  logic          pin_pages;
  logic          in_valid, in_ready, in_ytile, in_rec_b17;
  logic [AW-1:0] in_addr;
  logic          out_valid, out_ready, out_ytile, out_b17_moved;
  logic [AW-1:0] out_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_swz_unit #(.ADDR_W(AW), .CFG_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .mode_x(mode_x), .mode_y(mode_y), .pin_pages(pin_pages),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_ytile(in_ytile), .in_rec_b17(in_rec_b17),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_ytile(out_ytile), .out_b17_moved(out_b17_moved)
  );

  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(logic [AW-1:0] a, int m);
    logic f;
    logic [AW-1:0] r;
    case (m)
      1: f = a[9];
      2: f = a[9] ^ a[10];
      3: f = a[9] ^ a[11];
      4: f = a[9] ^ a[10] ^ a[11];
      5: f = a[9] ^ a[17];
      6: f = a[9] ^ a[10] ^ a[17];
      default: f = 1'b0;
    endcase
    r = a;
    r[6] = a[6] ^ f;
    return r;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1 out_valid", 64'(out_valid), 64'd0);
    check_eq("R1 in_ready", 64'(in_ready), 64'd1);
    check_eq("R1 mode_x", 64'(mode_x), 64'd0);
    check_eq("R1 mode_y", 64'(mode_y), 64'd0);
    check_eq("R1 pin_pages", 64'(pin_pages), 64'd0);
  endtask

  task automatic t_cfg(string tag, logic [CW-1:0] w, int ex, int ey, bit ep);
    logic [2:0] old_x;
    @(negedge clk);
    old_x = mode_x;
    cfg_word = w;
    #1;
    check_eq({tag, " R11 still old"}, 64'(mode_x), 64'(old_x));
    @(negedge clk);
    check_eq({tag, " mode_x"}, 64'(mode_x), 64'(ex));
    check_eq({tag, " mode_y"}, 64'(mode_y), 64'(ey));
    check_eq({tag, " pin"}, 64'(pin_pages), 64'(ep));
  endtask

  task automatic t_send(string tag, logic [AW-1:0] a, bit y, bit rec, int m);
    @(negedge clk);
    in_addr = a; in_ytile = y; in_rec_b17 = rec; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_eq({tag, " R10 valid"}, 64'(out_valid), 64'd1);
    check_eq({tag, " addr"}, 64'(out_addr), 64'(model(a, m)));
    check_eq({tag, " R5 ytile"}, 64'(out_ytile), 64'(y));
    check_eq({tag, " R9 moved"}, 64'(out_b17_moved), 64'(a[17] ^ rec));
  endtask

  task automatic t_modes_sweep(string tag, int mx, int my);
    logic [AW-1:0] pats [6];
    pats[0] = 40'h00_0000_0000;
    pats[1] = 40'h00_0000_0200;
    pats[2] = 40'h00_0000_0640;
    pats[3] = 40'h00_0002_0E40;
    pats[4] = 40'h00_0002_0840;
    pats[5] = 40'hA5_0002_0A7F;
    for (int i = 0; i < 6; i++) begin
      t_send({tag, " X"}, pats[i], 1'b0, pats[i][17], mx);
      t_send({tag, " Y"}, pats[i], 1'b1, pats[i][17], my);
    end
  endtask

  task automatic t_stall();
    logic [AW-1:0] a0, a1;
    a0 = 40'h12_0000_0240;
    a1 = 40'h34_0002_0600;
    out_ready = 1'b0;
    @(negedge clk);
    in_addr = a0; in_ytile = 1'b0; in_rec_b17 = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_addr = a1; in_ytile = 1'b1; in_rec_b17 = 1'b0;
    check_eq("R10 stall in_ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    check_eq("R10 hold addr", 64'(out_addr), 64'(model(a0, 2)));
    check_eq("R10 hold valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1;
    check_eq("R10 ready follows out_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R10 next addr", 64'(out_addr), 64'(model(a1, 1)));
    check_eq("R9 moved after stall", 64'(out_b17_moved), 64'd1);
    @(negedge clk);
    check_eq("R10 drains", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_word = '0; in_valid = 1'b0; in_addr = '0;
    in_ytile = 1'b0; in_rec_b17 = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_send("R2 none", 40'hFF_FFFF_FFFF, 1'b0, 1'b1, 0);
    t_cfg("R6 single", 8'h00, 0, 0, 1'b0);
    t_cfg("R6 asym", 8'h01, 0, 0, 1'b0);
    t_modes_sweep("R2 asym none", 0, 0);
    t_cfg("R7 xor off", 8'h06, 2, 1, 1'b0);
    t_modes_sweep("R3", 2, 1);
    t_cfg("R7 bit11", 8'h02, 4, 3, 1'b0);
    t_modes_sweep("R4 b11", 4, 3);
    t_cfg("R7 bit17", 8'h0A, 6, 5, 1'b0);
    t_modes_sweep("R4 b17", 6, 5);
    t_send("R9 mismatch", 40'h00_0002_0000, 1'b0, 1'b0, 6);
    t_send("R9 match", 40'h00_0002_0000, 1'b0, 1'b1, 6);
    t_cfg("R8 ambiguous", 8'h12, 0, 0, 1'b1);
    t_cfg("R8 reserved", 8'h03, 0, 0, 1'b1);
    t_cfg("R8 all ones", 8'hFF, 0, 0, 1'b1);
    t_send("R8 none applied", 40'h00_0000_0E00, 1'b1, 1'b0, 0);
    t_cfg("R7 xor off again", 8'h06, 2, 1, 1'b0);
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule